// File: doc/BRIEF.md
# Glitch-Free Base Clock Switch

This block picks one of two free-running clocks, an oscillator clock or a divided VCO clock, as the source of a base clock. A select input, sampled on the oscillator clock, names the wanted source. The change of source runs as a handshake across both clock domains. The old source is gated off on its own falling edge. The new source is gated on only after the old gate is seen closed in the new domain. While the handoff runs, neither gate is open, so the switched clock stays low and the base clock does not move.

The switched clock drives a divide-by-two stage, which gives a base clock with a 50% duty cycle. A second divide-by-two gives a bus clock at half the base rate, which is one quarter of the selected source. A status output names the source that is driving the output. It changes only after the new source's gate has opened. A select change that arrives while a switch is still running is held and applied once that switch has finished.

Top module: `cks_base_clk_switch`

## Requirements
- R1: While `rst_n` is low, `base_clk`, `bus_clk` and `src_vco` are 0. After reset the oscillator clock is the source, so the `base_clk` period is two oscillator periods.
- R2: After `sel_vco` changes to a value different from `src_vco`, `src_vco` takes the new value within 16 oscillator cycles.
- R3: The two source gates are never open at the same time. No interval between consecutive edges of `base_clk` is shorter than one period of the faster source, including across a switch.
- R4: `base_clk` has a period of twice the selected source period and a high time of exactly one source period.
- R5: `bus_clk` has a period of twice the `base_clk` period.
- R6: `src_vco` = 1 means the VCO clock drives the output and 0 means the oscillator clock does. When the oscillator gate is open, `src_vco` reads 0 from the next oscillator edge on.
- R7: A change of `sel_vco` made while a switch is in progress does not alter the switch under way. It is applied after the switch completes, so a short pulse on `sel_vco` still produces a full switch to the VCO and then back.
- R8: Holding `sel_vco` at the value already in effect causes no switch: `src_vco` stays put and `base_clk` keeps its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_osc | input | 1 | Oscillator clock, also the clock for `sel_vco` |
| clk_vco | input | 1 | Divided VCO clock |
| sel_vco | input | 1 | 1 requests the VCO clock, 0 the oscillator clock |
| base_clk | output | 1 | Switched clock divided by two |
| bus_clk | output | 1 | Base clock divided by two |
| src_vco | output | 1 | Source currently driving the output (1 = VCO) |

## Verification
A new select value can arrive in the same oscillator cycle in which the handshake is still moving through its synchronizers. The register that holds the pending request must then keep its value while the gates change. To provoke this, the bench drives `sel_vco` high for a single oscillator cycle and low again on the next. It then checks that `src_vco` first reaches 1 and afterwards returns to 0, and it keeps checking the minimum spacing of `base_clk` edges throughout, so a pulse from a runt or a torn handoff would show up as a gap that is too short.

// File: rtl/cks_pkg.sv
package cks_pkg;
  typedef enum logic {
    SRC_OSC = 1'b0,
    SRC_VCO = 1'b1
  } src_e;

  localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/cks_sync.sv
module cks_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cks_leg.sv
module cks_leg #(
  parameter int   STAGES = 2,
  parameter logic EN_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic other_en,
  output logic en
);
  logic want, want_s;

  // open this gate only when asked and the other gate is closed
  assign want = req & ~other_en;

  cks_sync #(.STAGES(STAGES), .RST_VAL(EN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (want),
    .q     (want_s)
  );

  // gate changes while this clock is low, so no partial pulse escapes
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= EN_RST;
    else        en <= want_s;
  end
endmodule

// File: rtl/cks_div2.sv
module cks_div2 (
  input  logic clk_in,
  input  logic rst_n,
  output logic q
);
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= ~q;
  end
endmodule

// File: rtl/cks_base_clk_switch.sv
module cks_base_clk_switch #(
  parameter int SYNC_STAGES = cks_pkg::SYNC_STAGES_DEF
) (
  input  logic rst_n,
  input  logic clk_osc,
  input  logic clk_vco,
  input  logic sel_vco,
  output logic base_clk,
  output logic bus_clk,
  output logic src_vco
);
  logic sel_eff;
  logic osc_en, vco_en, vco_en_s;
  logic mux_clk;

  // pending request: accepted only when no switch is running
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)                sel_eff <= cks_pkg::SRC_OSC;
    else if (sel_eff == src_vco) sel_eff <= sel_vco;
  end

  cks_leg #(.STAGES(SYNC_STAGES), .EN_RST(1'b1)) u_leg_osc (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .req      (~sel_eff),
    .other_en (vco_en),
    .en       (osc_en)
  );

  cks_leg #(.STAGES(SYNC_STAGES), .EN_RST(1'b0)) u_leg_vco (
    .clk      (clk_vco),
    .rst_n    (rst_n),
    .req      (sel_eff),
    .other_en (osc_en),
    .en       (vco_en)
  );

  cks_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_vco_seen (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .d     (vco_en),
    .q     (vco_en_s)
  );

  // status follows the gate that has actually opened
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)        src_vco <= cks_pkg::SRC_OSC;
    else if (osc_en)   src_vco <= cks_pkg::SRC_OSC;
    else if (vco_en_s) src_vco <= cks_pkg::SRC_VCO;
  end

  assign mux_clk = (clk_osc & osc_en) | (clk_vco & vco_en);

  cks_div2 u_div_base (
    .clk_in (mux_clk),
    .rst_n  (rst_n),
    .q      (base_clk)
  );

  cks_div2 u_div_bus (
    .clk_in (base_clk),
    .rst_n  (rst_n),
    .q      (bus_clk)
  );

  // R3: gates exclusive, seen from each domain
  a_r3_one_source: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !(osc_en && vco_en));
  a_r3_one_source_vco: assert property (@(posedge clk_vco) disable iff (!rst_n)
    !(osc_en && vco_en));
  // R6: open oscillator gate is reported on the next edge
  a_r6_status_osc: assert property (@(posedge clk_osc) disable iff (!rst_n)
    osc_en |=> (src_vco == 1'b0));
  // R7: pending request frozen while a switch runs
  a_r7_hold_pending: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (sel_eff != src_vco) |=> $stable(sel_eff));
endmodule

// File: tb/tb_cks_base_clk_switch.sv
`timescale 1ns/1ps
module tb_cks_base_clk_switch;
  localparam int NV = 6;
  // {sel, base period ns, bus period ns}
  localparam int VEC [NV][3] = '{
    '{0, 40, 80}, '{1, 28, 56}, '{1, 28, 56},
    '{0, 40, 80}, '{1, 28, 56}, '{0, 40, 80}
  };

  logic rst_n = 1'b0, clk_osc = 1'b0, clk_vco = 1'b0, sel_vco = 1'b0;
  logic base_clk, bus_clk, src_vco;
  int n_chk = 0, n_fail = 0, osc_cyc = 0;
  bit mon_on = 1'b0;
  realtime last_edge = 0.0, min_gap = 1.0e9;

  cks_base_clk_switch dut (
    .rst_n(rst_n), .clk_osc(clk_osc), .clk_vco(clk_vco), .sel_vco(sel_vco),
    .base_clk(base_clk), .bus_clk(bus_clk), .src_vco(src_vco)
  );

  always #10 clk_osc = ~clk_osc;
  initial begin #3; forever #7 clk_vco = ~clk_vco; end

  always @(base_clk) begin
    if (mon_on && last_edge > 0.0 && ($realtime - last_edge) < min_gap)
      min_gap = $realtime - last_edge;
    last_edge = $realtime;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_osc) begin
    osc_cyc++;
    if (osc_cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", osc_cyc, 150000);
      finish_run();
    end
  end

  task automatic measure(input string req, input int exp_base, input int exp_bus);
    realtime t0, t1, t2, b0, b1;
    repeat (4) @(posedge base_clk);
    @(posedge base_clk); t0 = $realtime;
    @(negedge base_clk); t1 = $realtime;
    @(posedge base_clk); t2 = $realtime;
    check($rtoi(t2 - t0 + 0.5) == exp_base, {req, " R4 base period"},
          $rtoi(t2 - t0 + 0.5), exp_base);
    check($rtoi(t1 - t0 + 0.5) == exp_base / 2, {req, " R4 base high time"},
          $rtoi(t1 - t0 + 0.5), exp_base / 2);
    @(posedge bus_clk); b0 = $realtime;
    @(posedge bus_clk); b1 = $realtime;
    check($rtoi(b1 - b0 + 0.5) == exp_bus, {req, " R5 bus period"},
          $rtoi(b1 - b0 + 0.5), exp_bus);
  endtask

  initial begin
    int n;
    bit saw_vco;
    #50;
    // R1: reset state
    check(base_clk == 1'b0, "R1 base in reset", base_clk, 0);
    check(bus_clk == 1'b0, "R1 bus in reset", bus_clk, 0);
    check(src_vco == 1'b0, "R1 status in reset", src_vco, 0);
    @(negedge clk_osc); rst_n = 1'b1; mon_on = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bit prev;
      prev = src_vco;
      @(negedge clk_osc); sel_vco = VEC[i][0][0];
      n = 0;
      while (src_vco != VEC[i][0][0] && n < 40) begin
        @(negedge clk_osc); n++;
      end
      if (prev != VEC[i][0][0])
        check(n <= 16, "R2 switch latency", n, 16);
      else
        check(n == 0, "R8 same select no switch", n, 0);
      check(src_vco == VEC[i][0][0], "R6 status value", src_vco, VEC[i][0]);
      measure("R1/R8 vector", VEC[i][1], VEC[i][2]);
    end

    // R7: one-cycle select pulse during a switch
    @(negedge clk_osc); sel_vco = 1'b1;
    @(negedge clk_osc); sel_vco = 1'b0;
    saw_vco = 1'b0; n = 0;
    while (n < 80) begin
      @(negedge clk_osc); n++;
      if (src_vco) saw_vco = 1'b1;
      if (saw_vco && !src_vco) break;
    end
    check(saw_vco, "R7 pulse reached VCO", saw_vco, 1);
    check(src_vco == 1'b0, "R7 returned to oscillator", src_vco, 0);
    measure("R7 after pulse", 40, 80);

    // R1: reset while on VCO
    @(negedge clk_osc); sel_vco = 1'b1;
    n = 0;
    while (!src_vco && n < 40) begin @(negedge clk_osc); n++; end
    check(src_vco == 1'b1, "R6 on VCO before reset", src_vco, 1);
    mon_on = 1'b0; sel_vco = 1'b0;
    rst_n = 1'b0; #15;
    check(src_vco == 1'b0, "R1 status after mid reset", src_vco, 0);
    check(base_clk == 1'b0, "R1 base after mid reset", base_clk, 0);
    @(negedge clk_osc); rst_n = 1'b1;
    measure("R1 after mid reset", 40, 80);

    // R3: no runt spacing on base clock
    check(min_gap >= 13.9, "R3 min base edge spacing ps", $rtoi(min_gap * 1000.0), 14000);
    finish_run();
  end
endmodule